// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-interface master for talking to external Ethernet PHYs over a two-wire MDC/MDIO bus. It sits on a plain 32-bit register bus and exposes four registers: configuration/status, command, data and extended address. Software never pokes the serial line directly. Writing one of the registers launches a complete serial management frame as a side effect, and software then polls a busy flag until the frame has ended.

One configuration bit picks between the two standard frame encodings: the legacy direct-register form (Clause 22) and the extended, address-then-access form (Clause 45). In extended mode, writing the address register emits an address frame. In both modes, writing the data register emits a write frame, and setting the read bit in the command register emits a read frame. When a read completes, the data register holds the 16 bits taken from the PHY until the next frame starts. A turnaround bit that the PHY leaves undriven is reported as a read error.

MDC is derived from the system clock by a programmable divider and rests low between frames. MDIO leaves the block as separate output, output-enable and input pins, so a pad cell outside the block can build the open-drain line.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The register window decodes byte offsets 0x30 (status/config), 0x34 (command), 0x38 (data) and 0x3C (address). Every register resets to zero, and any other offset reads zero.
- R2: Status/config bits 0 (busy) and 1 (read error) are read-only. Bit 6 (1 = Clause 45, 0 = Clause 22) and bits 15:8 (divider field) read back as written. The command register reads back bits 4:0 (device/register), 9:5 (port), 10 (preamble off), 11 and 14 (spare) as written, and bit 15 (read) always reads 0.
- R3: MDC is low whenever no frame is in progress. While a frame runs, each MDC half period lasts F system clocks, where F is the divider field, and a field of 0 acts as 1.
- R4: Every frame is start(2), opcode(2), port(5), device/register(5), turnaround(2) and data(16), sent MSB first. It is preceded by 32 one bits unless command bit 10 was set when the frame started.
- R5: In Clause 22 mode the start field is 01, the write opcode is 01 and the read opcode is 10.
- R6: In Clause 45 mode the start field is 00 and the opcodes are 00 (address), 01 (write) and 11 (read). A write to the address register starts an address frame carrying bits 15:0 only in Clause 45 mode. In Clause 22 mode the value is only stored.
- R7: A write to the data register stores bits 15:0 and starts a write frame, with the turnaround driven as 10. Busy reads 1 from the cycle after the write until the MDC fall that ends the last bit. The output enable is low whenever busy is low.
- R8: Setting command bit 15 starts a read frame using the port, device and preamble bits of that same write. The output enable drops for the turnaround and data bits. The 16 bits sampled on MDC rising edges are placed in the data register when busy clears and are held there until the next frame.
- R9: The read-error bit is set if MDIO is not 0 at the rising edge of the second turnaround bit. It is cleared when the next frame starts.
- R10: While busy is 1, a data-register write, an address-register write, and a command write with bit 15 set are all ignored: no frame starts and no register changes.
- R11: MDIO output and output-enable change only while MDC is low, never during an MDC high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
A wrong bit index or a wrong shift in the frame engine changes the serial stream that a PHY model captures on MDC rising edges. It therefore appears as a wrong frame word or a wrong count of driven bits within one frame, which is at most 64 MDC periods. A stuck or early busy flag shows up in the busy bit of the status register and in MDC pulses outside a frame, within a cycle of the fault. A slip in the read-capture window corrupts the data register and the read-error bit as soon as busy falls, and a busy-time write that leaks through shows up as a second frame or as a changed register value right after the first frame ends.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int OFF_STAT = 'h30;
   localparam int OFF_CTL  = 'h34;
   localparam int OFF_DATA = 'h38;
   localparam int OFF_ADDR = 'h3C;

   localparam int FRAME_BITS = 32;

   typedef enum logic [1:0] {
      FR_ADDR  = 2'd0,
      FR_WRITE = 2'd1,
      FR_READ  = 2'd2
   } frame_kind_t;

   // Compose the 32-bit body of a management frame, MSB sent first.
   function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic        ext_mode,
      input frame_kind_t kind,
      input logic [4:0]  port,
      input logic [4:0]  dev,
      input logic [15:0] payload);
      logic [1:0] st;
      logic [1:0] op;
      logic [1:0] ta;
      st = ext_mode ? 2'b00 : 2'b01;
      unique case (kind)
         FR_ADDR:  op = 2'b00;
         FR_WRITE: op = 2'b01;
         default:  op = ext_mode ? 2'b11 : 2'b10;
      endcase
      ta = (kind == FR_READ) ? 2'b11 : 2'b10;
      return {st, op, port, dev, ta, payload};
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] half_m1;
   logic             mdc_q;
   logic             wrap;

   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("mdio_mdc_gen: DIV_W must be at least 1");
      end
   endgenerate

   assign half_m1   = (half_div == '0) ? '0 : half_div - DIV_W'(1);
   assign wrap      = run && (cnt_q == half_m1);
   assign rise_tick = wrap && !mdc_q;
   assign fall_tick = wrap &&  mdc_q;
   assign mdc       = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= !mdc_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
   parameter int SH_W  = 64,
   parameter int IDX_W = $clog2(SH_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SH_W-1:0]  load_vec,
   input  logic [IDX_W-1:0] last_idx,
   input  logic [IDX_W-1:0] cut_idx,
   input  logic             is_read,
   input  logic             rise_tick,
   input  logic             fall_tick,
   input  logic             mdio_i,
   output logic             busy,
   output logic             oe,
   output logic             tx_bit,
   output logic             rx_valid,
   output logic [15:0]      rx_data,
   output logic             rd_err
);

   logic [SH_W-1:0]  sh_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] cut_q;
   logic [IDX_W-1:0] ta2_idx;
   logic             rd_q;
   logic             busy_q;
   logic             oe_q;
   logic             err_q;
   logic [15:0]      rx_q;
   logic             at_last;

   generate
      if (SH_W < 32) begin : g_bad_sh
         $error("mdio_frame_engine: SH_W must hold a full frame");
      end
   endgenerate

   assign ta2_idx = cut_q + IDX_W'(1);
   assign at_last = (idx_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         idx_q  <= '0;
         last_q <= '0;
         cut_q  <= '0;
         rd_q   <= 1'b0;
         busy_q <= 1'b0;
         oe_q   <= 1'b0;
         err_q  <= 1'b0;
         rx_q   <= '0;
      end else if (start && !busy_q) begin
         sh_q   <= load_vec;
         idx_q  <= '0;
         last_q <= last_idx;
         cut_q  <= cut_idx;
         rd_q   <= is_read;
         busy_q <= 1'b1;
         oe_q   <= 1'b1;
         err_q  <= 1'b0;
      end else if (busy_q) begin
         if (rise_tick && rd_q) begin
            if (idx_q == ta2_idx) begin
               err_q <= mdio_i;
            end else if (idx_q > ta2_idx) begin
               rx_q <= {rx_q[14:0], mdio_i};
            end
         end
         if (fall_tick) begin
            if (at_last) begin
               busy_q <= 1'b0;
               oe_q   <= 1'b0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
               sh_q  <= sh_q << 1;
               if (rd_q && (idx_q + IDX_W'(1) == cut_q)) begin
                  oe_q <= 1'b0;
               end
            end
         end
      end
   end

   assign busy     = busy_q;
   assign oe       = oe_q;
   assign tx_bit   = sh_q[SH_W-1];
   assign rx_valid = busy_q && fall_tick && at_last && rd_q;
   assign rx_data  = rx_q;
   assign rd_err   = err_q;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DIV_W   = 8,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   localparam int SH_W  = PRE_LEN + FRAME_BITS;
   localparam int IDX_W = $clog2(SH_W);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
   localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(OFF_ADDR);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("mdio_mgmt_master: ADDR_W too small for the register window");
      end
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("mdio_mgmt_master: DIV_W must be 1..8");
      end
      if (PRE_LEN < 0 || PRE_LEN > 32) begin : g_bad_pre
         $error("mdio_mgmt_master: PRE_LEN must be 0..32");
      end
   endgenerate

   // Register state
   logic             ext_q;
   logic [DIV_W-1:0] div_q;
   logic [4:0]       dev_q;
   logic [4:0]       port_q;
   logic             nopre_q;
   logic             spare11_q;
   logic             spare14_q;
   logic [15:0]      data_q;
   logic [15:0]      addr_q;

   // Engine links
   logic              busy_w;
   logic              rd_err_w;
   logic              rx_valid;
   logic [15:0]       rx_data;
   logic              rise_tick;
   logic              fall_tick;
   logic              tx_bit;

   // Frame launch
   logic              go;
   frame_kind_t       kind;
   logic [4:0]        f_port;
   logic [4:0]        f_dev;
   logic              f_nopre;
   logic [15:0]       f_payload;
   logic [FRAME_BITS-1:0] body;
   logic [SH_W-1:0]   load_vec;
   logic [IDX_W-1:0]  last_idx;
   logic [IDX_W-1:0]  cut_idx;

   logic wr_stat, wr_ctl, wr_data, wr_addr;
   assign wr_stat = bus_we && (bus_addr == A_STAT);
   assign wr_ctl  = bus_we && (bus_addr == A_CTL);
   assign wr_data = bus_we && (bus_addr == A_DATA);
   assign wr_addr = bus_we && (bus_addr == A_ADDR);

   always_comb begin
      go        = 1'b0;
      kind      = FR_WRITE;
      f_port    = port_q;
      f_dev     = dev_q;
      f_nopre   = nopre_q;
      f_payload = bus_wdata[15:0];
      if (!busy_w) begin
         if (wr_ctl && bus_wdata[15]) begin
            go        = 1'b1;
            kind      = FR_READ;
            f_port    = bus_wdata[9:5];
            f_dev     = bus_wdata[4:0];
            f_nopre   = bus_wdata[10];
            f_payload = 16'hFFFF;
         end else if (wr_data) begin
            go   = 1'b1;
            kind = FR_WRITE;
         end else if (wr_addr && ext_q) begin
            go   = 1'b1;
            kind = FR_ADDR;
         end
      end
   end

   assign body = build_frame(ext_q, kind, f_port, f_dev, f_payload);

   generate
      if (PRE_LEN > 0) begin : g_pre
         assign load_vec = f_nopre ? {body, {PRE_LEN{1'b0}}}
                                   : {{PRE_LEN{1'b1}}, body};
         assign last_idx = f_nopre ? IDX_W'(FRAME_BITS - 1) : IDX_W'(SH_W - 1);
         assign cut_idx  = f_nopre ? IDX_W'(14) : IDX_W'(PRE_LEN + 14);
      end else begin : g_nopre
         assign load_vec = body;
         assign last_idx = IDX_W'(FRAME_BITS - 1);
         assign cut_idx  = IDX_W'(14);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q     <= 1'b0;
         div_q     <= '0;
         dev_q     <= '0;
         port_q    <= '0;
         nopre_q   <= 1'b0;
         spare11_q <= 1'b0;
         spare14_q <= 1'b0;
         data_q    <= '0;
         addr_q    <= '0;
      end else begin
         if (wr_stat) begin
            ext_q <= bus_wdata[6];
            div_q <= bus_wdata[8 +: DIV_W];
         end
         if (wr_ctl && !(bus_wdata[15] && busy_w)) begin
            dev_q     <= bus_wdata[4:0];
            port_q    <= bus_wdata[9:5];
            nopre_q   <= bus_wdata[10];
            spare11_q <= bus_wdata[11];
            spare14_q <= bus_wdata[14];
         end
         if (wr_data && !busy_w) begin
            data_q <= bus_wdata[15:0];
         end else if (rx_valid) begin
            data_q <= rx_data;
         end
         if (wr_addr && !busy_w) begin
            addr_q <= bus_wdata[15:0];
         end
      end
   end

   logic [7:0] div_rd;
   assign div_rd = 8'(div_q);

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_STAT:  bus_rdata = {16'h0, div_rd, 1'b0, ext_q, 4'h0, rd_err_w, busy_w};
         A_CTL:   bus_rdata = {16'h0, 1'b0, spare14_q, 2'b00, spare11_q, nopre_q,
                               port_q, dev_q};
         A_DATA:  bus_rdata = {16'h0, data_q};
         A_ADDR:  bus_rdata = {16'h0, addr_q};
         default: bus_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[13:12], bus_wdata[7],
                           bus_wdata[5:0]};

   mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_gen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_w),
      .half_div  (div_q),
      .mdc       (mdc_o),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_engine #(.SH_W(SH_W), .IDX_W(IDX_W)) engine_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (go),
      .load_vec  (load_vec),
      .last_idx  (last_idx),
      .cut_idx   (cut_idx),
      .is_read   (kind == FR_READ),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .busy      (busy_w),
      .oe        (mdio_oe),
      .tx_bit    (tx_bit),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rd_err    (rd_err_w)
   );

   assign mdio_o = tx_bit;

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
   input logic clk,
   input logic rst_n,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe,
   input logic busy,
   input logic rd_err
);

   a_r3_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   a_r3_rise_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> busy);

   a_r7_oe_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   a_r7_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (mdio_oe && !mdc));

   a_r11_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   a_r9_err_moves_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_err) |-> (busy || $past(busy)));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .mdc     (mdc_o),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .busy    (busy_w),
   .rd_err  (rd_err_w)
);

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;

   localparam int ADDR_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              mdc_o;
   logic              mdio_o;
   logic              mdio_oe;
   logic              mdio_i = 1'b1;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mdio_mgmt_master #(.ADDR_W(ADDR_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .mdc_o     (mdc_o),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .mdio_i    (mdio_i)
   );

   // PHY model: captures driven bits, answers reads
   logic [63:0] drv_bits = '0;
   int          drv_cnt = 0;
   int          rise_cnt = 0;
   int          phy_base = 32;
   logic        phy_ta2 = 1'b0;
   logic [15:0] phy_rd = '0;

   always @(posedge mdc_o) begin
      if (mdio_oe) begin
         drv_bits = {drv_bits[62:0], mdio_o};
         drv_cnt++;
      end
      rise_cnt++;
   end

   function automatic logic phy_bit(input int i);
      if (i == phy_base + 15) return phy_ta2;
      if (i >= phy_base + 16 && i < phy_base + 32) return phy_rd[15 - (i - phy_base - 16)];
      return 1'b1;
   endfunction

   always @(negedge mdc_o) mdio_i <= phy_bit(rise_cnt);

   task automatic clear_mon(input int base);
      drv_bits = '0;
      drv_cnt  = 0;
      rise_cnt = 0;
      phy_base = base;
      mdio_i   = 1'b1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 20000; i++) begin
         bus_rd(8'h30, s);
         if (!s[0]) return;
      end
      chk(1'b0, "R7 busy never cleared", 1, 0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      bus_rd(8'h30, d); chk(d == 0, "R1 status reset", d, 0);
      bus_rd(8'h34, d); chk(d == 0, "R1 command reset", d, 0);
      bus_rd(8'h38, d); chk(d == 0, "R1 data reset", d, 0);
      bus_rd(8'h3C, d); chk(d == 0, "R1 address reset", d, 0);
      bus_rd(8'h00, d); chk(d == 0, "R1 unmapped offset", d, 0);
      chk(!mdc_o && !mdio_oe, "R3 idle lines", {mdc_o, mdio_oe}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      bus_wr(8'h30, 32'h0000_0543);
      bus_rd(8'h30, d);
      chk(d == 32'h0000_0540, "R2 status rw and ro bits", d, 32'h540);
      bus_wr(8'h34, 32'h0000_4C21);
      bus_rd(8'h34, d);
      chk(d == 32'h0000_4C21, "R2 command readback", d, 32'h4C21);
      bus_wr(8'h30, 32'h0000_0100);
   endtask

   task automatic t_c22_write();
      logic [31:0] d;
      logic [63:0] exp;
      clear_mon(32);
      bus_wr(8'h34, {22'h0, 5'h03, 5'h11});
      bus_wr(8'h38, 32'h0000_A5C3);
      bus_rd(8'h30, d);
      chk(d[0] == 1'b1, "R7 busy during write", d[0], 1);
      wait_idle();
      exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h11, 2'b10, 16'hA5C3};
      chk(drv_cnt == 64, "R4 preamble bit count", drv_cnt, 64);
      chk(drv_bits == exp, "R5 clause22 write frame", drv_bits, exp);
      chk(!mdc_o, "R3 mdc low after frame", mdc_o, 0);
   endtask

   task automatic t_c22_read();
      logic [31:0] d;
      logic [13:0] exp;
      clear_mon(0);
      phy_ta2 = 1'b0;
      phy_rd  = 16'h3C96;
      bus_wr(8'h34, {16'h0, 1'b1, 4'b0, 1'b1, 5'h1A, 5'h02});
      wait_idle();
      exp = {2'b01, 2'b10, 5'h1A, 5'h02};
      chk(drv_cnt == 14, "R8 oe released at turnaround", drv_cnt, 14);
      chk(drv_bits[13:0] == exp, "R5 clause22 read header no preamble",
          drv_bits[13:0], exp);
      bus_rd(8'h38, d);
      chk(d == 32'h3C96, "R8 read data captured", d, 32'h3C96);
      bus_rd(8'h30, d);
      chk(d[1] == 1'b0, "R9 no error when ta2 low", d[1], 0);
      bus_rd(8'h34, d);
      chk(d[15] == 1'b0, "R2 read bit reads zero", d[15], 0);
   endtask

   task automatic t_c22_addr_store();
      logic [31:0] d;
      clear_mon(32);
      bus_wr(8'h3C, 32'h0000_00AA);
      repeat (10) @(negedge clk);
      bus_rd(8'h30, d);
      chk(d[0] == 1'b0 && drv_cnt == 0, "R6 no address frame in clause22",
          drv_cnt, 0);
      bus_rd(8'h3C, d);
      chk(d == 32'hAA, "R6 address stored in clause22", d, 32'hAA);
   endtask

   task automatic t_c45_addr();
      logic [63:0] exp;
      bus_wr(8'h30, 32'h0000_0240);
      clear_mon(32);
      bus_wr(8'h34, {22'h0, 5'h07, 5'h1E});
      bus_wr(8'h3C, 32'h0000_1234);
      wait_idle();
      exp = {32'hFFFF_FFFF, 2'b00, 2'b00, 5'h07, 5'h1E, 2'b10, 16'h1234};
      chk(drv_cnt == 64 && drv_bits == exp, "R6 clause45 address frame",
          drv_bits, exp);
   endtask

   task automatic t_c45_read_err();
      logic [31:0] d;
      logic [45:0] exp;
      clear_mon(32);
      phy_ta2 = 1'b1;
      phy_rd  = 16'h0F0F;
      bus_wr(8'h34, {16'h0, 1'b1, 4'b0, 1'b0, 5'h07, 5'h1E});
      wait_idle();
      exp = {32'hFFFF_FFFF, 2'b00, 2'b11, 5'h07, 5'h1E};
      chk(drv_cnt == 46 && drv_bits[45:0] == exp, "R6 clause45 read header",
          drv_bits[45:0], exp);
      bus_rd(8'h30, d);
      chk(d[1] == 1'b1, "R9 error when ta2 high", d[1], 1);
   endtask

   task automatic t_c45_write_busy();
      logic [31:0] d;
      logic [63:0] exp;
      clear_mon(32);
      bus_wr(8'h38, 32'h0000_BEEF);
      bus_rd(8'h30, d);
      chk(d[1] == 1'b0, "R9 error cleared at next frame", d[1], 0);
      bus_wr(8'h38, 32'h0000_1111);
      bus_wr(8'h3C, 32'h0000_5555);
      bus_wr(8'h34, {16'h0, 1'b1, 4'b0, 1'b1, 5'h01, 5'h01});
      wait_idle();
      repeat (20) @(negedge clk);
      exp = {32'hFFFF_FFFF, 2'b00, 2'b01, 5'h07, 5'h1E, 2'b10, 16'hBEEF};
      chk(drv_cnt == 64 && drv_bits == exp, "R10 single write frame",
          drv_bits, exp);
      bus_rd(8'h38, d);
      chk(d == 32'hBEEF, "R10 data kept", d, 32'hBEEF);
      bus_rd(8'h3C, d);
      chk(d == 32'h1234, "R10 address kept", d, 32'h1234);
      bus_rd(8'h34, d);
      chk(d == {22'h0, 5'h07, 5'h1E}, "R10 command kept", d, {5'h07, 5'h1E});
   endtask

   task automatic t_divider();
      time t0, t1;
      bus_wr(8'h30, 32'h0000_0300);
      clear_mon(32);
      bus_wr(8'h38, 32'h0000_0001);
      @(posedge mdc_o); t0 = $time;
      @(posedge mdc_o); t1 = $time;
      chk((t1 - t0) == 120, "R3 mdc period for field 3", t1 - t0, 120);
      wait_idle();
      chk(drv_cnt == 64, "R11 full frame at slower mdc", drv_cnt, 64);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_c22_write();
      t_c22_read();
      t_c22_addr_store();
      t_c45_addr();
      t_c45_read_err();
      t_c45_write_busy();
      t_divider();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule